// File: doc/BRIEF.md
# 4B/5B Transmit Code-Group Encoder

This block forms the transmit side of a 100 Mb/s physical coding sublayer. Every clock it accepts one 4-bit nibble together with a frame-enable strobe and an error strobe. It returns one 5-bit code-group, which a downstream serializer consumes. Between frames it fills the line with IDLE code-groups. When a frame opens, it replaces the first two nibbles with the start-of-stream delimiter pair J, K. It maps each later nibble through the 4B/5B data table. When the frame closes, it appends the end-of-stream delimiter pair T, R and then returns to IDLE.

A mode input selects 10 Mb/s operation. In that mode the encoder is bypassed and each nibble appears on the output unencoded, and the framing sequencer is held in its idle state. The output is registered, so each code-group appears one clock after the inputs it was formed from are sampled.

Top module: `pcs_tx_coder`

## Requirements
- R1: While reset is asserted, and on every clock in 100 Mb/s mode with no frame in progress and enable low, the output is IDLE = 5'b11111. Every output is registered: it appears one clock after the inputs that produced it are sampled.
- R2: On the first clock on which enable is sampled high after an idle period, the nibble is discarded and J = 5'b11000 is emitted.
- R3: On the clock after J, the nibble is discarded and K = 5'b10001 is emitted, whatever the enable level.
- R4: From the third enabled clock onward, each nibble 0..F is emitted as, in order, 11110, 01001, 10100, 10101, 01010, 01011, 01110, 01111, 10010, 10011, 10110, 10111, 11010, 11011, 11100, 11101.
- R5: An error strobe sampled high together with enable in the data phase emits HALT = 5'b00100 in place of that nibble's code.
- R6: The first clock with enable low after the data phase emits T = 5'b01101, the next emits R = 5'b00111, and IDLE follows.
- R7: Enable high for a single clock yields exactly J, K, T, R, then IDLE.
- R8: If enable rises again while T or R is being sent, the delimiter completes and the nibbles sampled meanwhile are dropped. The first nibble sampled high after R gets J and the next gets K.
- R9: With the mode input low (10 Mb/s), the output is {1'b0, nibble} on every clock. Any frame in progress is abandoned, so the next enabled clock in 100 Mb/s mode starts with J.
- R10: The error strobe has no effect on the J and K code-groups.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock, one nibble per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| fast_mode_i | input | 1 | 1 = 100 Mb/s coded mode, 0 = 10 Mb/s bypass |
| tx_en_i | input | 1 | Frame enable from the MAC |
| tx_er_i | input | 1 | Transmit error strobe |
| nib_i | input | 4 | Data nibble |
| cg_o | output | 5 | Registered code-group toward the serializer |

## Verification
Two functions can fall on the same clock: closing one frame with T, R and opening the next one. The bench provokes this by dropping enable for a single clock and raising it again while R is due. It then expects T, R, J, K in strict order, with the nibbles sampled during R lost. The error strobe and the start-of-stream delimiter can also coincide. The bench holds the error strobe high across the first two enabled clocks and still expects J, K rather than HALT. A scoreboard model built from the requirement text predicts each code-group one clock after its stimulus.

// File: rtl/pcs_tx_pkg.sv
package pcs_tx_pkg;
    localparam int NIB_W = 4;
    localparam int CG_W  = NIB_W + 1;

    typedef logic [NIB_W-1:0] nib_t;
    typedef logic [CG_W-1:0]  cg_t;

    localparam cg_t CG_IDLE = 5'b11111;
    localparam cg_t CG_J    = 5'b11000;
    localparam cg_t CG_K    = 5'b10001;
    localparam cg_t CG_T    = 5'b01101;
    localparam cg_t CG_R    = 5'b00111;
    localparam cg_t CG_HALT = 5'b00100;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_K,
        ST_DATA,
        ST_T,
        ST_R
    } fstate_e;

    typedef enum logic [2:0] {
        SEL_IDLE,
        SEL_J,
        SEL_K,
        SEL_T,
        SEL_R,
        SEL_HALT,
        SEL_DATA,
        SEL_RAW
    } sel_e;
endpackage

// File: rtl/pcs_nib_enc.sv
module pcs_nib_enc
    import pcs_tx_pkg::*;
(
    input  nib_t nib_i,
    output cg_t  code_o
);
    always_comb begin
        unique case (nib_i)
            4'h0: code_o = 5'b11110;
            4'h1: code_o = 5'b01001;
            4'h2: code_o = 5'b10100;
            4'h3: code_o = 5'b10101;
            4'h4: code_o = 5'b01010;
            4'h5: code_o = 5'b01011;
            4'h6: code_o = 5'b01110;
            4'h7: code_o = 5'b01111;
            4'h8: code_o = 5'b10010;
            4'h9: code_o = 5'b10011;
            4'hA: code_o = 5'b10110;
            4'hB: code_o = 5'b10111;
            4'hC: code_o = 5'b11010;
            4'hD: code_o = 5'b11011;
            4'hE: code_o = 5'b11100;
            default: code_o = 5'b11101;
        endcase
    end
endmodule

// File: rtl/pcs_tx_seq.sv
module pcs_tx_seq
    import pcs_tx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fast_i,
    input  logic en_i,
    input  logic er_i,
    output sel_e sel_o
);
    typedef struct packed {
        fstate_e st;
    } seq_s;

    seq_s seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        sel_o = SEL_IDLE;
        if (!fast_i) begin
            sel_o    = SEL_RAW;
            seq_d.st = ST_IDLE;
        end else begin
            unique case (seq_q.st)
                ST_IDLE: begin
                    if (en_i) begin
                        sel_o    = SEL_J;
                        seq_d.st = ST_K;
                    end
                end
                ST_K: begin
                    sel_o    = SEL_K;
                    seq_d.st = en_i ? ST_DATA : ST_T;
                end
                ST_DATA: begin
                    if (en_i) begin
                        sel_o = er_i ? SEL_HALT : SEL_DATA;
                    end else begin
                        sel_o    = SEL_T;
                        seq_d.st = ST_R;
                    end
                end
                ST_T: begin
                    sel_o    = SEL_T;
                    seq_d.st = ST_R;
                end
                default: begin
                    sel_o    = SEL_R;
                    seq_d.st = ST_IDLE;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q.st <= ST_IDLE;
        end else begin
            seq_q <= seq_d;
        end
    end

    // R6: a pending T is always followed by R while in coded mode
    p_t_before_r_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == ST_T && fast_i) |=> (seq_q.st == ST_R));

    // R9: bypass mode abandons any frame in progress
    p_slow_resets_frame_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!fast_i) |=> (seq_q.st == ST_IDLE));
endmodule

// File: rtl/pcs_tx_coder.sv
module pcs_tx_coder
    import pcs_tx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fast_mode_i,
    input  logic             tx_en_i,
    input  logic             tx_er_i,
    input  logic [NIB_W-1:0] nib_i,
    output logic [CG_W-1:0]  cg_o
);
    typedef struct packed {
        cg_t cg;
    } out_s;

    out_s out_d, out_q;
    sel_e sel;
    cg_t  data_cg;

    pcs_tx_seq u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .fast_i (fast_mode_i),
        .en_i   (tx_en_i),
        .er_i   (tx_er_i),
        .sel_o  (sel)
    );

    pcs_nib_enc u_enc (
        .nib_i  (nib_i),
        .code_o (data_cg)
    );

    always_comb begin
        out_d = out_q;
        unique case (sel)
            SEL_J:    out_d.cg = CG_J;
            SEL_K:    out_d.cg = CG_K;
            SEL_T:    out_d.cg = CG_T;
            SEL_R:    out_d.cg = CG_R;
            SEL_HALT: out_d.cg = CG_HALT;
            SEL_DATA: out_d.cg = data_cg;
            SEL_RAW:  out_d.cg = {1'b0, nib_i};
            default:  out_d.cg = CG_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q.cg <= CG_IDLE;
        end else begin
            out_q <= out_d;
        end
    end

    assign cg_o = out_q.cg;

    // Mode that produced the code-group currently on cg_o
    logic mode_prev_q;
    always_ff @(posedge clk) begin
        if (!rst_n) mode_prev_q <= 1'b1;
        else        mode_prev_q <= fast_mode_i;
    end

    // R1: quiet line stays idle
    p_quiet_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_prev_q && fast_mode_i && !tx_en_i && cg_o == CG_IDLE) |=> (cg_o == CG_IDLE));

    // R3: J is always followed by K in coded mode
    p_j_then_k_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cg_o == CG_J && fast_mode_i) |=> (cg_o == CG_K));

    // R6: T is always followed by R in coded mode
    p_t_then_r_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cg_o == CG_T && mode_prev_q && fast_mode_i) |=> (cg_o == CG_R));

    // R8: after R only IDLE or a fresh J may follow
    p_r_then_idle_or_j_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cg_o == CG_R && mode_prev_q && fast_mode_i) |=> (cg_o == CG_IDLE || cg_o == CG_J));

    // R9: bypass passes the nibble straight through
    p_raw_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!fast_mode_i) |=> (cg_o == {1'b0, $past(nib_i)}));
endmodule

// File: tb/sim_pcs_tx_coder.sv
module sim_pcs_tx_coder;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       fast_mode_i;
    logic       tx_en_i;
    logic       tx_er_i;
    logic [3:0] nib_i;
    logic [4:0] cg_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    typedef struct {
        logic [4:0] exp;
        string      tag;
    } item_t;

    item_t sb_q[$];
    int    ms = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pcs_tx_coder u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .fast_mode_i (fast_mode_i),
        .tx_en_i     (tx_en_i),
        .tx_er_i     (tx_er_i),
        .nib_i       (nib_i),
        .cg_o        (cg_o)
    );

    function automatic logic [4:0] enc_ref(input logic [3:0] n);
        case (n)
            4'h0: return 5'b11110;  4'h1: return 5'b01001;
            4'h2: return 5'b10100;  4'h3: return 5'b10101;
            4'h4: return 5'b01010;  4'h5: return 5'b01011;
            4'h6: return 5'b01110;  4'h7: return 5'b01111;
            4'h8: return 5'b10010;  4'h9: return 5'b10011;
            4'hA: return 5'b10110;  4'hB: return 5'b10111;
            4'hC: return 5'b11010;  4'hD: return 5'b11011;
            4'hE: return 5'b11100;  default: return 5'b11101;
        endcase
    endfunction

    task automatic drive(input logic en, input logic er, input logic [3:0] nib,
                         input logic fast, input string tag);
        logic [4:0] e;
        @(negedge clk);
        tx_en_i = en; tx_er_i = er; nib_i = nib; fast_mode_i = fast;
        if (!fast) begin
            e = {1'b0, nib}; ms = 0;
        end else begin
            case (ms)
                0: if (en) begin e = 5'b11000; ms = 1; end else e = 5'b11111;
                1: begin e = 5'b10001; ms = en ? 2 : 3; end
                2: if (en) e = er ? 5'b00100 : enc_ref(nib);
                   else begin e = 5'b01101; ms = 4; end
                3: begin e = 5'b01101; ms = 4; end
                default: begin e = 5'b00111; ms = 0; end
            endcase
        end
        sb_q.push_back('{exp: e, tag: tag});
    endtask

    always @(posedge clk) begin
        if (rst_n) begin
            #1;
            if (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                n_tests++;
                if (cg_o !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: cg_o=%b expected=%b", it.tag, cg_o, it.exp);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: run hung, actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; fast_mode_i = 1'b1; tx_en_i = 1'b1; tx_er_i = 1'b0; nib_i = 4'h5;
        repeat (3) @(negedge clk);
        n_tests++;
        if (cg_o !== 5'b11111) begin
            n_fail++;
            $display("FAIL R1 reset: cg_o=%b expected=%b", cg_o, 5'b11111);
        end
        tx_en_i = 1'b0;
        rst_n = 1'b1;

        // R1: idle line
        repeat (3) drive(0, 0, 4'h3, 1, "R1");
        // R2/R3/R4/R6: full frame carrying every nibble value
        drive(1, 0, 4'h5, 1, "R2");
        drive(1, 0, 4'h5, 1, "R3");
        for (int i = 0; i < 16; i++) drive(1, 0, 4'(i), 1, "R4");
        drive(0, 0, 4'h0, 1, "R6");
        drive(0, 0, 4'h0, 1, "R6");
        drive(0, 0, 4'h0, 1, "R6");
        // R5: error mid-frame
        drive(1, 0, 4'h5, 1, "R5");
        drive(1, 0, 4'h5, 1, "R5");
        drive(1, 0, 4'h3, 1, "R5");
        drive(1, 1, 4'hA, 1, "R5");
        drive(1, 0, 4'h7, 1, "R5");
        drive(0, 1, 4'h7, 1, "R5");
        drive(0, 0, 4'h0, 1, "R5");
        drive(0, 0, 4'h0, 1, "R5");
        // R10: error during the start delimiter is ignored
        drive(1, 1, 4'hE, 1, "R10");
        drive(1, 1, 4'hE, 1, "R10");
        drive(1, 0, 4'h1, 1, "R10");
        drive(0, 0, 4'h0, 1, "R10");
        drive(0, 0, 4'h0, 1, "R10");
        drive(0, 0, 4'h0, 1, "R10");
        // R7: single-clock enable
        drive(1, 0, 4'h9, 1, "R7");
        repeat (5) drive(0, 0, 4'h9, 1, "R7");
        // R8: enable re-raised while the end delimiter is in flight
        drive(1, 0, 4'h5, 1, "R8");
        drive(1, 0, 4'h5, 1, "R8");
        drive(1, 0, 4'hC, 1, "R8");
        drive(0, 0, 4'h0, 1, "R8");
        drive(1, 0, 4'h2, 1, "R8");
        drive(1, 0, 4'h5, 1, "R8");
        drive(1, 0, 4'h5, 1, "R8");
        drive(1, 0, 4'hB, 1, "R8");
        drive(0, 0, 4'h0, 1, "R8");
        drive(1, 0, 4'h4, 1, "R8");
        drive(1, 0, 4'h4, 1, "R8");
        drive(1, 0, 4'h4, 1, "R8");
        drive(1, 0, 4'h6, 1, "R8");
        drive(0, 0, 4'h0, 1, "R8");
        drive(0, 0, 4'h0, 1, "R8");
        drive(0, 0, 4'h0, 1, "R8");
        // R9: bypass mode, including a frame abandoned mid-way
        drive(1, 0, 4'h5, 1, "R9");
        drive(1, 0, 4'h5, 1, "R9");
        drive(1, 0, 4'h9, 0, "R9");
        drive(0, 0, 4'hA, 0, "R9");
        drive(1, 1, 4'hF, 0, "R9");
        drive(1, 0, 4'h0, 0, "R9");
        drive(1, 0, 4'hD, 1, "R9");
        drive(1, 0, 4'hD, 1, "R9");
        drive(1, 0, 4'h8, 1, "R9");
        drive(0, 0, 4'h0, 1, "R9");
        repeat (3) drive(0, 0, 4'h0, 1, "R1");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule